// File: doc/BRIEF.md
# Segmented Tapped Shift Register

This block is a static serial shift register of 64 single-bit stages. The stages form four chained segments of 16. It is meant for delay lines and small serial scratch memories. One bit enters at the serial input on every rising clock edge. The last stage of each segment is visible on a tap port, so the stored sequence can be watched at one quarter, one half, three quarters and the full length of the chain.

A write-enable input changes the role of the segment boundaries. While it is low, every stage takes the value of the stage before it, and all four tap drivers are enabled. While it is high, every tap driver is released. The first stage of segments two, three and four then loads from a tap input instead of from the end of the previous segment. Four bits enter per clock, so a full 64-bit image goes in with 16 edges.

Each bidirectional tap is modelled as three separate signals: a value out, a value in and an output enable. A pad ring or bus wrapper can then form the real three-state pin. The register has no reset. It holds its contents for as long as the clock stays idle.

Top module: `ssr_tapped_chain`

## Requirements
- R1: With writeEn held at 0, the bit presented on serialIn before a rising edge appears on tapOut[3] after exactly 64 rising edges, counting that edge as the first.
- R2: With writeEn at 0, tapOut[k] shows stage 16*(k+1): a bit entered at one edge is on tapOut[0] after 16 edges, on tapOut[1] after 32 edges and on tapOut[2] after 48 edges.
- R3: Stage 1 loads serialIn at every rising edge, whatever the level of writeEn.
- R4: When writeEn is 1 at a rising edge, stages 17, 33 and 49 load tapIn[0], tapIn[1] and tapIn[2]. Every other stage except stage 1 loads its predecessor.
- R5: Sixteen edges with writeEn at 1 fill all 64 stages, one bit per segment per edge. The image then reads back intact on the four taps while shifting with writeEn at 0.
- R6: tapOe is 4'b1111 while writeEn is 0 and 4'b0000 while writeEn is 1. It follows writeEn without waiting for a clock edge.
- R7: With no clock edge, the stage contents and tapOut stay unchanged, whatever the changes on serialIn, tapIn and writeEn.
- R8: While writeEn is 0, tapIn has no effect: stages 17, 33 and 49 load stages 16, 32 and 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all stages |
| writeEn | input | 1 | 0: plain shift with taps driven; 1: parallel entry at inner taps, taps released |
| serialIn | input | 1 | Serial data into stage 1 |
| tapIn | input | 3 | Inner tap input values; bit k feeds stage 16*(k+1)+1 when writeEn is 1 |
| tapOut | output | 4 | Tap values; bit k is stage 16*(k+1) |
| tapOe | output | 4 | Tap output enables; bit k enables tapOut[k] onto a shared bus |

## Verification
There is no reset, so a stage that holds a wrong value stays hidden until that value moves past a tap. In the worst case this takes 15 edges for an error at the head of a segment, or up to 63 edges when read only at the last tap. The bench therefore compares all four taps after every edge against a bit-level model. An error in the segment boundary multiplexer shows at the next tap within 16 edges of the faulty load. An output-enable fault shows at once, because tapOe is combinational on writeEn.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic segLoad;   // inner segment heads take the tap inputs
    logic tapDrive;  // tap drivers enabled
  } ssr_ctrl_t;

endpackage

// File: rtl/ssr_segment.sv
module ssr_segment #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           dIn,
  output logic [LEN-1:0] q
);

  // q[0] is the head stage; q[LEN-1] is the tail that feeds the tap.
  always_ff @(posedge clk) begin
    q <= {q[LEN-2:0], dIn};
  end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic      writeEn,
  output ssr_ctrl_t ctrl
);

  always_comb begin
    ctrl.segLoad  = writeEn;
    ctrl.tapDrive = ~writeEn;
  end

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4,
  localparam int TOTAL  = SEG_LEN * NUM_SEG
) (
  input  logic               clk,
  input  logic               serialIn,
  input  logic [NUM_SEG-2:0] tapIn,
  input  ssr_ctrl_t          ctrl,
  output logic [NUM_SEG-1:0] tapOut,
  output logic [TOTAL-1:0]   chainQ
);

  logic [NUM_SEG-1:0] segIn;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [SEG_LEN-1:0] segQ;

    if (s == 0) begin : g_head
      assign segIn[s] = serialIn;
    end else begin : g_inner
      // Boundary selects: parallel entry in write mode, chain otherwise.
      assign segIn[s] = ctrl.segLoad ? tapIn[s-1] : tapOut[s-1];
    end

    ssr_segment #(.LEN(SEG_LEN)) u_seg (
      .clk (clk),
      .dIn (segIn[s]),
      .q   (segQ)
    );

    assign tapOut[s]                    = segQ[SEG_LEN-1];
    assign chainQ[s*SEG_LEN +: SEG_LEN] = segQ;
  end

endmodule

// File: rtl/ssr_tapped_chain.sv
module ssr_tapped_chain
  import ssr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4,
  localparam int TOTAL  = SEG_LEN * NUM_SEG
) (
  input  logic               clk,
  input  logic               writeEn,
  input  logic               serialIn,
  input  logic [NUM_SEG-2:0] tapIn,
  output logic [NUM_SEG-1:0] tapOut,
  output logic [NUM_SEG-1:0] tapOe
);

  ssr_ctrl_t        ctrl;
  logic [TOTAL-1:0] chainQ;

  ssr_ctrl u_ctrl (
    .writeEn (writeEn),
    .ctrl    (ctrl)
  );

  ssr_datapath #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_dp (
    .clk      (clk),
    .serialIn (serialIn),
    .tapIn    (tapIn),
    .ctrl     (ctrl),
    .tapOut   (tapOut),
    .chainQ   (chainQ)
  );

  assign tapOe = {NUM_SEG{ctrl.tapDrive}};

endmodule

// File: rtl/ssr_chain_checker.sv
module ssr_chain_checker #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4,
  localparam int TOTAL  = SEG_LEN * NUM_SEG
) (
  input logic               clk,
  input logic               writeEn,
  input logic               serialIn,
  input logic [NUM_SEG-2:0] tapIn,
  input logic [NUM_SEG-1:0] tapOut,
  input logic [NUM_SEG-1:0] tapOe,
  input logic [TOTAL-1:0]   chainQ
);

  // No reset exists; checks start after the first edge.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_stage1_serial_r3: assert property (@(posedge clk) disable iff (!armed)
    1'b1 |=> chainQ[0] == $past(serialIn));

  p_last_tap_shift_r1: assert property (@(posedge clk) disable iff (!armed)
    1'b1 |=> tapOut[NUM_SEG-1] == $past(chainQ[TOTAL-2]));

  p_oe_follow_r6: assert property (@(posedge clk) disable iff (!armed)
    tapOe == {NUM_SEG{~writeEn}});

  for (genvar s = 1; s < NUM_SEG; s++) begin : g_bnd
    p_inner_load_r4: assert property (@(posedge clk) disable iff (!armed)
      writeEn |=> chainQ[s*SEG_LEN] == $past(tapIn[s-1]));

    p_inner_chain_r8: assert property (@(posedge clk) disable iff (!armed)
      !writeEn |=> chainQ[s*SEG_LEN] == $past(chainQ[s*SEG_LEN-1]));
  end

endmodule

bind ssr_tapped_chain ssr_chain_checker #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_chk (
  .clk      (clk),
  .writeEn  (writeEn),
  .serialIn (serialIn),
  .tapIn    (tapIn),
  .tapOut   (tapOut),
  .tapOe    (tapOe),
  .chainQ   (chainQ)
);

// File: tb/tb_ssr_tapped_chain.sv
module tb_ssr_tapped_chain;
  localparam int SL  = 16;
  localparam int NS  = 4;
  localparam int TOT = SL * NS;

  logic          clk = 1'b0;
  bit            clkRun = 1'b1;
  logic          writeEn = 1'b0;
  logic          serialIn = 1'b0;
  logic [NS-2:0] tapIn = '0;
  logic [NS-1:0] tapOut, tapOe;

  ssr_tapped_chain #(.SEG_LEN(SL), .NUM_SEG(NS)) dut (
    .clk(clk), .writeEn(writeEn), .serialIn(serialIn),
    .tapIn(tapIn), .tapOut(tapOut), .tapOe(tapOe)
  );

  typedef struct {
    logic [NS-1:0] oe;
    logic [NS-1:0] tap;
    string         tag;
  } exp_t;

  exp_t           sbQ[$];
  int             checks = 0;
  int             fails = 0;
  logic [TOT-1:0] refQ;  // refQ[0] models stage 1

  initial forever #2 if (clkRun) clk = ~clk;

  task automatic compare(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one edge of stimulus and pushes the expected outputs.
  task automatic step(input logic we, input logic sin, input logic [NS-2:0] tin,
                      input string tag, input bit chk);
    logic [TOT-1:0] nxt;
    exp_t e;
    @(negedge clk);
    writeEn = we; serialIn = sin; tapIn = tin;
    nxt[0] = sin;
    for (int i = 1; i < TOT; i++)
      nxt[i] = (we && (i % SL) == 0) ? tin[i/SL-1] : refQ[i-1];
    refQ = nxt;
    if (chk) begin
      e.oe = {NS{~we}};
      for (int k = 0; k < NS; k++) e.tap[k] = refQ[k*SL+SL-1];
      e.tag = tag;
      sbQ.push_back(e);
    end
  endtask

  // Monitor: compares after each edge, away from the edge itself.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sbQ.size() > 0) begin
      e = sbQ.pop_front();
      compare(e.tag, tapOut, e.tap);
      compare("R6", tapOe, e.oe);
    end
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NS-1:0] snap;
    #1;
    compare("R6", tapOe, 4'b1111);  // initial state, writeEn low
    // Fill with known data (no reset exists).
    for (int i = 0; i < TOT; i++) step(1'b0, (i % 3) == 0, '0, "", 1'b0);
    // R1: serial stream with full-length latency tracked by the model.
    for (int i = 0; i < TOT; i++) step(1'b0, ((i * 7) % 5) < 2, '0, "R1", 1'b1);
    // R2: single one travelling through zeros, seen at each tap in turn.
    for (int i = 0; i < TOT; i++) step(1'b0, 1'b0, '0, "", 1'b0);
    step(1'b0, 1'b1, '0, "R2", 1'b1);
    for (int i = 0; i < TOT; i++) step(1'b0, 1'b0, '0, "R2", 1'b1);
    // R8: tapIn toggling while writeEn is low must not matter.
    for (int i = 0; i < 40; i++) step(1'b0, i[0], 3'(i), "R8", 1'b1);
    // R4: parallel load of a full image in 16 edges.
    for (int i = 0; i < SL; i++) step(1'b1, i[1], 3'(i * 5 + 3), "R4", 1'b1);
    // R5: read the image back over 16 shifting edges on all taps.
    for (int i = 0; i < SL; i++) step(1'b0, 1'b0, 3'b111, "R5", 1'b1);
    for (int i = 0; i < SL; i++) step(1'b0, 1'b1, 3'b000, "R5", 1'b1);
    // R3: mixed modes; stage 1 always follows serialIn.
    for (int i = 0; i < 48; i++) step((i % 5) == 0, (i % 4) < 2, 3'(i * 3), "R3", 1'b1);
    // R7: stop the clock low, disturb every input, contents must hold.
    repeat (3) @(negedge clk);
    clkRun = 1'b0;
    #1;
    snap = tapOut;
    serialIn = ~serialIn; tapIn = ~tapIn; writeEn = 1'b1;
    #20;
    compare("R7", tapOut, snap);
    compare("R6", tapOe, 4'b0000);
    writeEn = 1'b0; tapIn = 3'b101;
    #20;
    compare("R7", tapOut, snap);
    compare("R6", tapOe, 4'b1111);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule